// File: doc/BRIEF.md
# Segment Page Translation and Access Check Unit

This unit turns a segment-relative displacement into a physical address. It checks the access right for the referenced page before it produces any address. A request carries five things: the port bits of the plaintext handle in use, the running thread's domain mask, the segment's size in pages with the base index of its page table, the displacement, and a read/write flag.

The displacement splits into a page number and an offset within the page. The page number is first bounded against the segment size. The page-table entry is then fetched from a small internal RAM. The right for the requested direction must be present in at least one context that the handle port and the domain mask both enable; an owner bit in the port overrides this check. Last, the entry's presence bit is tested. The unit answers with either a physical address or one fault code, two cycles after it accepts the request.

The page-table RAM is loaded through a simple write port. One request is in flight at a time.

Top module: `seg_page_xlate`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_done` is 1 for exactly one cycle, two clock edges after that acceptance. `req_ready` is 0 from acceptance until the edge after the done cycle.
- R3: The page number is `req_disp[11:8]` and the offset is `req_disp[7:0]`. The page-table entry read is at index (`seg_ptbase` + page number) modulo `PT_DEPTH`, and `PT_DEPTH` is a power of two.
- R4: A page number greater than or equal to `seg_size` gives fault code 1 (addressing). This code outranks every other fault.
- R5: A read uses the entry's read-context field, entry bits [13:10]. A write uses the write-context field, entry bits [17:14]. When the selected field ANDed with `dom_mask` and `hnd_port[3:0]` is all zero, and the owner bit is clear, the fault code is 2 (protection).
- R6: When `hnd_port[4]` (owner) is 1, no protection fault is raised, whatever the fields and `dom_mask` hold.
- R7: When the access is permitted but the entry's presence bit (entry bit 18) is 0, the fault code is 3 (page absent). A protection fault outranks page absent.
- R8: With no fault, the fault code is 0 and `rsp_paddr` is the entry frame (entry bits [9:0]) joined above the 8-bit offset.
- R9: On any fault, `rsp_paddr` is zero.
- R10: A clock edge with `pt_wr_en` at 1 stores `pt_wr_data` at `pt_wr_addr`. A later translation that selects that index uses the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_disp | input | 12 | Displacement within the segment |
| hnd_port | input | 5 | Handle port; bit 4 is the owner context |
| dom_mask | input | 4 | Current domain contexts |
| seg_size | input | 5 | Segment size in pages |
| seg_ptbase | input | PT_AW | Page-table base index |
| pt_wr_en | input | 1 | Page-table write strobe |
| pt_wr_addr | input | PT_AW | Page-table write index |
| pt_wr_data | input | 19 | Entry {present, write field, read field, frame} |
| rsp_done | output | 1 | Result valid, one cycle |
| rsp_fault | output | 2 | 0 none, 1 addressing, 2 protection, 3 absent |
| rsp_paddr | output | 18 | Physical address, zero on fault |

## Verification
Two cases let more than one fault condition hold in the same cycle.

The first is an entry whose presence bit is clear while no enabled context grants the access. It is provoked with an absent entry whose field bits are masked off either by the domain or by the port. Only code 2 is accepted for it, and the same entry with a granting context must then give code 3.

The second is an out-of-range page number whose index lands on an entry that would also deny or be absent. Here code 1 is the only correct answer. Random requests exercise both overlaps, and the bench model settles the winning code by the fixed priority.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
    localparam int CTX_W   = 5;
    localparam int RIGHT_W = CTX_W - 1;
    localparam int PN_W    = 4;
    localparam int OFF_W   = 8;
    localparam int DISP_W  = PN_W + OFF_W;
    localparam int SIZE_W  = PN_W + 1;
    localparam int FRAME_W = 10;
    localparam int PA_W    = FRAME_W + OFF_W;

    typedef struct packed {
        logic               present;
        logic [RIGHT_W-1:0] wr_ctx;
        logic [RIGHT_W-1:0] rd_ctx;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ADDR   = 2'd1,
        FLT_PROT   = 2'd2,
        FLT_ABSENT = 2'd3
    } fault_e;

    function automatic logic ctx_grant(input logic [RIGHT_W-1:0] field,
                                       input logic [RIGHT_W-1:0] dom,
                                       input logic [CTX_W-1:0]   port);
        return port[CTX_W-1] | (|(field & dom & port[RIGHT_W-1:0]));
    endfunction
endpackage

// File: rtl/xlt_bounds.sv
`timescale 1ns/1ps
module xlt_bounds
    import seg_xlate_pkg::*;
#(
    parameter int PT_AW = 5
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [SIZE_W-1:0] size,
    input  logic [PT_AW-1:0]  base,
    output logic [OFF_W-1:0]  offset,
    output logic              out_of_range,
    output logic [PT_AW-1:0]  pt_index
);
    localparam int SUM_W = (PT_AW > PN_W) ? PT_AW : PN_W;

    logic [PN_W-1:0]  page;
    logic [SUM_W-1:0] sum;

    always_comb begin
        page         = disp[DISP_W-1:OFF_W];
        offset       = disp[OFF_W-1:0];
        out_of_range = ({1'b0, page} >= size);
        sum          = SUM_W'(base) + SUM_W'(page);
        pt_index     = sum[PT_AW-1:0];
    end
endmodule

// File: rtl/xlt_pt_ram.sv
`timescale 1ns/1ps
module xlt_pt_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int DW    = 19
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xlt_rights.sv
`timescale 1ns/1ps
module xlt_rights
    import seg_xlate_pkg::*;
(
    input  logic               write,
    input  logic [RIGHT_W-1:0] rd_ctx,
    input  logic [RIGHT_W-1:0] wr_ctx,
    input  logic [RIGHT_W-1:0] dom,
    input  logic [CTX_W-1:0]   port,
    output logic               grant
);
    logic [RIGHT_W-1:0] field;

    always_comb begin
        field = write ? wr_ctx : rd_ctx;
        grant = ctx_grant(field, dom, port);
    end
endmodule

// File: rtl/seg_page_xlate.sv
`timescale 1ns/1ps
module seg_page_xlate
    import seg_xlate_pkg::*;
#(
    parameter  int PT_DEPTH = 32,
    localparam int PT_AW    = $clog2(PT_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [DISP_W-1:0]  req_disp,
    input  logic [CTX_W-1:0]   hnd_port,
    input  logic [RIGHT_W-1:0] dom_mask,
    input  logic [SIZE_W-1:0]  seg_size,
    input  logic [PT_AW-1:0]   seg_ptbase,
    input  logic               pt_wr_en,
    input  logic [PT_AW-1:0]   pt_wr_addr,
    input  logic [PTE_W-1:0]   pt_wr_data,
    output logic               rsp_done,
    output logic [1:0]         rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr
);
    // stage 1: captured request
    logic               s1_valid;
    logic               s1_write;
    logic [DISP_W-1:0]  s1_disp;
    logic [CTX_W-1:0]   s1_port;
    logic [RIGHT_W-1:0] s1_dom;
    logic [SIZE_W-1:0]  s1_size;
    logic [PT_AW-1:0]   s1_base;

    // stage 1 decode
    logic [OFF_W-1:0]   s1_off;
    logic               s1_oob;
    logic [PT_AW-1:0]   s1_idx;

    // stage 2: entry available
    logic               s2_valid;
    logic               s2_write;
    logic [OFF_W-1:0]   s2_off;
    logic [CTX_W-1:0]   s2_port;
    logic [RIGHT_W-1:0] s2_dom;
    logic               s2_oob;
    logic [PTE_W-1:0]   pte_raw;
    pte_t               pte_q;
    logic               s2_grant;
    fault_e             s2_fault;

    logic accept;

    assign req_ready = !s1_valid && !s2_valid;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= accept;
        end
        if (accept) begin
            s1_write <= req_write;
            s1_disp  <= req_disp;
            s1_port  <= hnd_port;
            s1_dom   <= dom_mask;
            s1_size  <= seg_size;
            s1_base  <= seg_ptbase;
        end
    end

    xlt_bounds #(.PT_AW(PT_AW)) u_bounds (
        .disp         (s1_disp),
        .size         (s1_size),
        .base         (s1_base),
        .offset       (s1_off),
        .out_of_range (s1_oob),
        .pt_index     (s1_idx)
    );

    xlt_pt_ram #(.DEPTH(PT_DEPTH), .AW(PT_AW), .DW(PTE_W)) u_ram (
        .clk   (clk),
        .we    (pt_wr_en),
        .waddr (pt_wr_addr),
        .wdata (pt_wr_data),
        .re    (s1_valid && !s1_oob),
        .raddr (s1_idx),
        .rdata (pte_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
        if (s1_valid) begin
            s2_write <= s1_write;
            s2_off   <= s1_off;
            s2_port  <= s1_port;
            s2_dom   <= s1_dom;
            s2_oob   <= s1_oob;
        end
    end

    assign pte_q = pte_t'(pte_raw);

    xlt_rights u_rights (
        .write  (s2_write),
        .rd_ctx (pte_q.rd_ctx),
        .wr_ctx (pte_q.wr_ctx),
        .dom    (s2_dom),
        .port   (s2_port),
        .grant  (s2_grant)
    );

    always_comb begin
        if (s2_oob)              s2_fault = FLT_ADDR;
        else if (!s2_grant)      s2_fault = FLT_PROT;
        else if (!pte_q.present) s2_fault = FLT_ABSENT;
        else                     s2_fault = FLT_NONE;
    end

    assign rsp_done  = s2_valid;
    assign rsp_fault = s2_valid ? s2_fault : FLT_NONE;
    assign rsp_paddr = (s2_valid && s2_fault == FLT_NONE) ? {pte_q.frame, s2_off} : '0;
endmodule

// File: rtl/xlt_checker.sv
`timescale 1ns/1ps
module xlt_checker
    import seg_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DISP_W-1:0] req_disp,
    input logic [CTX_W-1:0]  hnd_port,
    input logic [SIZE_W-1:0] seg_size,
    input logic              rsp_done,
    input logic [1:0]        rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr
);
    assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ##2 rsp_done);

    assert_busy_while_done_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready);

    assert_single_done_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_range_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && ({1'b0, $past(req_disp[DISP_W-1:OFF_W], 2)} >= $past(seg_size, 2)))
        |-> rsp_fault == FLT_ADDR);

    assert_owner_no_prot_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && $past(hnd_port[CTX_W-1], 2)) |-> rsp_fault != FLT_PROT);

    assert_offset_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault == FLT_NONE)
        |-> rsp_paddr[OFF_W-1:0] == $past(req_disp[OFF_W-1:0], 2));

    assert_zero_on_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != FLT_NONE) |-> rsp_paddr == '0);
endmodule

bind seg_page_xlate xlt_checker u_chk (.*);

// File: tb/sim_seg_page_xlate.sv
`timescale 1ns/1ps
module sim_seg_page_xlate;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [11:0] req_disp;
    logic [4:0]  hnd_port;
    logic [3:0]  dom_mask;
    logic [4:0]  seg_size;
    logic [4:0]  seg_ptbase;
    logic        pt_wr_en;
    logic [4:0]  pt_wr_addr;
    logic [18:0] pt_wr_data;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [17:0] rsp_paddr;

    logic [18:0] mirror [DEPTH];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    seg_page_xlate #(.PT_DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic wr, input logic [11:0] disp, input logic [4:0] port,
                                  input logic [3:0] dom, input logic [4:0] size, input logic [4:0] base,
                                  output logic [1:0] f, output logic [17:0] pa);
        logic [3:0]  page;
        logic [18:0] e;
        logic [3:0]  fld;
        logic        ok;
        page = disp[11:8];
        e    = mirror[5'(base + 5'(page))];
        fld  = wr ? e[17:14] : e[13:10];
        ok   = port[4] || ((fld & dom & port[3:0]) != 4'd0);
        if ({1'b0, page} >= size) f = 2'd1;
        else if (!ok)             f = 2'd2;
        else if (!e[18])          f = 2'd3;
        else                      f = 2'd0;
        pa = (f == 2'd0) ? {e[9:0], disp[7:0]} : 18'd0;
    endfunction

    task automatic put_entry(input logic [4:0] a, input logic [18:0] d);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_addr = a; pt_wr_data = d;
        @(negedge clk);
        pt_wr_en = 1'b0;
        mirror[a] = d;
    endtask

    task automatic xlate(input logic wr, input logic [11:0] disp, input logic [4:0] port,
                         input logic [3:0] dom, input logic [4:0] size, input logic [4:0] base,
                         input string tag);
        logic [1:0]  ef;
        logic [17:0] ep;
        model(wr, disp, port, dom, size, base, ef, ep);
        @(negedge clk);
        chk(req_ready, "R2 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_disp = disp; hnd_port = port;
        dom_mask = dom; seg_size = size; seg_ptbase = base;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_disp  = 12'($urandom); hnd_port = 5'($urandom);
        chk(!rsp_done && !req_ready, "R2 busy, no early done", {30'd0, rsp_done, req_ready}, 32'd0);
        @(negedge clk);
        chk(rsp_done === 1'b1, "R2 done after two edges", 32'(rsp_done), 32'd1);
        chk(rsp_fault === ef, tag, 32'(rsp_fault), 32'(ef));
        chk(rsp_paddr === ep, {tag, " R9 paddr"}, 32'(rsp_paddr), 32'(ep));
        @(negedge clk);
        chk(!rsp_done && req_ready, "R2 done one cycle, ready back", {30'd0, rsp_done, req_ready}, 32'd1);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_disp = '0; hnd_port = '0;
        dom_mask = '0; seg_size = '0; seg_ptbase = '0;
        pt_wr_en = 1'b0; pt_wr_addr = '0; pt_wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rsp_done && req_ready, "R1 reset state", {30'd0, rsp_done, req_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!rsp_done && req_ready, "R1 after reset", {30'd0, rsp_done, req_ready}, 32'd1);

        // R10: load the page table
        for (int i = 0; i < DEPTH; i++) put_entry(5'(i), 19'($urandom));

        // directed corner cases
        put_entry(5'd4, {1'b1, 4'b0000, 4'b0100, 10'h155});
        xlate(1'b0, 12'h2A7, 5'b00110, 4'b0100, 5'd8, 5'd2, "R8 read grant ctx2");
        xlate(1'b1, 12'h2A7, 5'b00110, 4'b0100, 5'd8, 5'd2, "R5 write uses W field");
        xlate(1'b0, 12'h2A7, 5'b00010, 4'b0110, 5'd8, 5'd2, "R5 port masks context");
        xlate(1'b0, 12'h2A7, 5'b00100, 4'b0010, 5'd8, 5'd2, "R5 domain masks context");
        xlate(1'b1, 12'h2A7, 5'b10000, 4'b0000, 5'd8, 5'd2, "R6 owner bypass");
        xlate(1'b0, 12'h800, 5'b11111, 4'b1111, 5'd8, 5'd2, "R4 page equals size");
        xlate(1'b0, 12'h000, 5'b11111, 4'b1111, 5'd0, 5'd2, "R4 empty segment");
        put_entry(5'd3, {1'b0, 4'b0001, 4'b0001, 10'h3FF});
        xlate(1'b0, 12'h510, 5'b00010, 4'b1111, 5'd16, 5'd30, "R7 prot outranks absent");
        xlate(1'b0, 12'h510, 5'b00001, 4'b1111, 5'd16, 5'd30, "R7 absent with grant, R3 wrap");
        xlate(1'b0, 12'h5FF, 5'b10000, 4'b0000, 5'd5, 5'd30, "R4 outranks absent");
        put_entry(5'd3, {1'b1, 4'b0001, 4'b0001, 10'h2C3});
        xlate(1'b1, 12'h5FF, 5'b00001, 4'b0001, 5'd16, 5'd30, "R10 rewritten entry R8");
        xlate(1'b0, 12'hF3C, 5'b00001, 4'b0001, 5'd16, 5'd18, "R3 last page");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [4:0] sz;
            sz = 5'($urandom_range(0, 16));
            if ((n % 40) == 0) put_entry(5'($urandom), 19'($urandom));
            xlate(1'($urandom), 12'($urandom), 5'($urandom), 4'($urandom), sz, 5'($urandom),
                  "R4 R5 R6 R7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule